// File: doc/BRIEF.md
# Three-Wire Configuration Port with Status Readback

This block is the slave end of a three-wire serial configuration link. A host shifts a word of up to 32 bits into the block, one bit per rising clock edge on the serial clock line, most significant bit first. A rising edge on the load strobe then copies the word into one of sixteen configuration registers. The four lowest bits of the word select that register. All sixteen register values are exposed in parallel to the rest of the chip, which gives them meaning.

One register address doubles as a readback request. If the loaded word targets that address and has its request bit set, the block captures a 16-bit status value from the chip at that moment. It then plays the value back on the serial output line, most significant bit first. The host keeps the load strobe high and clocks 18 cycles: one dummy bit, 16 data bits, and one cycle that releases the line. An enable-low chip-enable input makes the port deaf to everything.

The serial lines are sampled on the local system clock through synchronisers, so the serial clock must be several times slower than the system clock. The output driver is modelled as a data bit plus an output enable. A low enable stands for high impedance.

Top module: `cfg_serial_port`

## Requirements
- R1: During and after synchronous reset, all sixteen registers read zero and `sread_en_o` is low.
- R2: On each serial clock rising edge the shift register moves left by one and takes `sdata_i` into bit 0, so the first bit sent ends up as the most significant bit.
- R3: On a load strobe rising edge, the shift register content is written to the register whose index equals its bits [3:0]. No other register changes.
- R4: The shift register always holds the last 32 bits shifted. A shorter word keeps older bits above it, and a longer word keeps only its last 32 bits.
- R5: A readback starts only when the loaded word has index 7 and bit 8 set. A load to index 7 with bit 8 clear, or to any other index, leaves `sread_en_o` low.
- R6: The 16-bit `rb_value_i` is captured in the cycle the request word is loaded. Later changes to it do not alter the bits shifted out.
- R7: After a request is loaded, the output stays released until the first serial clock rising edge. That edge drives a dummy 0 with the enable high. Edges 2 to 17 drive captured bits 15 down to 0.
- R8: The 18th serial clock edge after the request releases the output (enable low). Further edges keep it released.
- R9: A falling edge of the load strobe ends a readback at once and releases the output.
- R10: While `ce_i` is low, serial clock and load strobe edges are ignored: the shift register, the registers and the readback state keep their values.
- R11: Dropping `ce_i` during a readback releases the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial lines are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Port enable; low makes the port ignore all activity |
| sclk_i | input | 1 | Serial clock from the host |
| sdata_i | input | 1 | Serial write data, MSB first |
| sle_i | input | 1 | Load strobe; rising edge loads, held high during readback |
| rb_value_i | input | 16 | Status value offered for readback |
| sread_o | output | 1 | Serial readback data |
| sread_en_o | output | 1 | Readback driver enable; low means high impedance |
| regs_o | output | 512 | Sixteen 32-bit registers, register i at bits [32*i+31:32*i] |

## Verification
Every one of the sixteen indices is written with a distinct arithmetic pattern, and all sixteen registers are checked after each load. This separates a wrong index decode from a stray write to another register. Words of 16 and 40 bits separate a shift register that clears on load from one that keeps a sliding window. Readback runs with all-zero, all-one, alternating and edge-bit patterns, with the status input flipped right after the request. This exposes bit-order faults, an off-by-one position of the dummy or release cycle, and a value taken late. Early strobe release, chip-enable loss mid-readback, and chip-enable-low activity show whether each abort and ignore path acts.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  localparam int SYNC_INPUTS = 4;
  localparam int IDX_CE    = 3;
  localparam int IDX_SCLK  = 2;
  localparam int IDX_SDATA = 1;
  localparam int IDX_SLE   = 0;

  typedef enum logic [1:0] {
    RB_IDLE  = 2'd0,
    RB_WAIT  = 2'd1,
    RB_SHIFT = 2'd2
  } rb_state_e;
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stage_q[STAGES-1];
  end

  assign lvl  = stage_q[STAGES-1];
  assign rise = stage_q[STAGES-1] & ~prev_q;
  assign fall = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cfg_shift_in.sv
module cfg_shift_in #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_o
);
  always_ff @(posedge clk) begin
    if (rst)       word_o <= '0;
    else if (step) word_o <= {word_o[WORD_W-2:0], bit_in};
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int NREG   = 16,
  parameter int WORD_W = 32,
  parameter int ADDR_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [WORD_W-1:0]      wdata,
  output logic [NREG*WORD_W-1:0] regs_o
);
  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_reg
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                            q <= '0;
        else if (we && addr == ADDR_W'(i))  q <= wdata;
      end
      assign regs_o[i*WORD_W +: WORD_W] = q;
    end
  endgenerate
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
  import cfg_serial_pkg::*;
#(
  parameter int RB_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            abort,
  input  logic            step,
  input  logic [RB_W-1:0] value_i,
  output logic            busy_o,
  output logic [RB_W-1:0] cap_o,
  output logic            sread_o,
  output logic            sread_en_o
);
  localparam int LAST_CNT = RB_W + 1;
  localparam int CNT_W    = $clog2(RB_W + 3);

  rb_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= RB_IDLE;
      cnt_q      <= '0;
      cap_o      <= '0;
      sread_o    <= 1'b0;
      sread_en_o <= 1'b0;
    end else if (abort) begin
      state_q    <= RB_IDLE;
      cnt_q      <= '0;
      sread_o    <= 1'b0;
      sread_en_o <= 1'b0;
    end else if (start) begin
      state_q    <= RB_WAIT;
      cnt_q      <= '0;
      cap_o      <= value_i;
      sread_o    <= 1'b0;
      sread_en_o <= 1'b0;
    end else if (step && state_q != RB_IDLE) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) begin
        state_q    <= RB_SHIFT;
        sread_o    <= 1'b0;
        sread_en_o <= 1'b1;
      end else if (cnt_q == CNT_W'(LAST_CNT)) begin
        state_q    <= RB_IDLE;
        sread_o    <= 1'b0;
        sread_en_o <= 1'b0;
      end else begin
        sread_o    <= cap_o[CNT_W'(RB_W) - cnt_q];
        sread_en_o <= 1'b1;
      end
    end
  end

  assign busy_o = (state_q != RB_IDLE);
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int NREG        = 16,
  parameter int WORD_W      = 32,
  parameter int RB_W        = 16,
  parameter int RB_ADDR     = 7,
  parameter int RB_REQ_BIT  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce_i,
  input  logic                   sclk_i,
  input  logic                   sdata_i,
  input  logic                   sle_i,
  input  logic [RB_W-1:0]        rb_value_i,
  output logic                   sread_o,
  output logic                   sread_en_o,
  output logic [NREG*WORD_W-1:0] regs_o
);
  localparam int ADDR_W = $clog2(NREG);

  logic [SYNC_INPUTS-1:0] raw, lvl, rise, fall;
  logic ce_s, sle_s, sclk_rise, sle_rise, sle_fall;
  logic shift_step, load, rb_start, rb_abort, rb_busy;
  logic [WORD_W-1:0] word;
  logic [RB_W-1:0]   rb_cap;

  assign raw[IDX_CE]    = ce_i;
  assign raw[IDX_SCLK]  = sclk_i;
  assign raw[IDX_SDATA] = sdata_i;
  assign raw[IDX_SLE]   = sle_i;

  cfg_sync_edge #(.W(SYNC_INPUTS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .din(raw), .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign ce_s      = lvl[IDX_CE];
  assign sle_s     = lvl[IDX_SLE];
  assign sclk_rise = rise[IDX_SCLK];
  assign sle_rise  = rise[IDX_SLE];
  assign sle_fall  = fall[IDX_SLE];

  assign shift_step = sclk_rise & ce_s;
  assign load       = sle_rise & ce_s;
  assign rb_start   = load && (word[ADDR_W-1:0] == ADDR_W'(RB_ADDR)) && word[RB_REQ_BIT];
  assign rb_abort   = sle_fall | ~ce_s;

  cfg_shift_in #(.WORD_W(WORD_W)) shift_i (
    .clk(clk), .rst(rst), .step(shift_step), .bit_in(lvl[IDX_SDATA]), .word_o(word)
  );

  cfg_reg_bank #(.NREG(NREG), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) bank_i (
    .clk(clk), .rst(rst), .we(load), .addr(word[ADDR_W-1:0]), .wdata(word),
    .regs_o(regs_o)
  );

  cfg_readback #(.RB_W(RB_W)) rb_i (
    .clk(clk), .rst(rst), .start(rb_start), .abort(rb_abort), .step(shift_step),
    .value_i(rb_value_i), .busy_o(rb_busy), .cap_o(rb_cap),
    .sread_o(sread_o), .sread_en_o(sread_en_o)
  );
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int NREG   = 16,
  parameter int WORD_W = 32,
  parameter int RB_W   = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   ce_s,
  input logic                   sle_s,
  input logic                   rb_busy,
  input logic [RB_W-1:0]        rb_cap,
  input logic                   sread_o,
  input logic                   sread_en_o,
  input logic [NREG*WORD_W-1:0] regs_o
);
  logic                   rst_d;
  logic [NREG*WORD_W-1:0] prev_regs;
  logic [NREG-1:0]        chg;

  always_ff @(posedge clk) begin
    rst_d     <= rst;
    prev_regs <= regs_o;
    if (rst_d) begin
      a_r1_reset_clears: assert (regs_o == '0 && !sread_en_o)
        else $error("R1 state not cleared after reset");
    end
  end

  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_chg
      assign chg[i] = regs_o[i*WORD_W +: WORD_W] != prev_regs[i*WORD_W +: WORD_W];
    end
  endgenerate

  a_r3_single_target: assert property (@(posedge clk) disable iff (rst)
    $countones(chg) <= 1);

  a_r10_ce_low_freezes: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> $stable(regs_o));

  a_r11_ce_low_releases: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> !sread_en_o);

  a_r9_sle_low_releases: assert property (@(posedge clk) disable iff (rst)
    !sle_s |=> !sread_en_o);

  a_r7_dummy_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(sread_en_o) |-> !sread_o);

  a_r6_capture_held: assert property (@(posedge clk) disable iff (rst)
    (rb_busy && $past(rb_busy) && !$rose(rb_busy) && sread_en_o) |-> $stable(rb_cap));

  a_r8_release_ends: assert property (@(posedge clk) disable iff (rst)
    $fell(sread_en_o) |-> !rb_busy);
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
  .NREG(NREG), .WORD_W(WORD_W), .RB_W(RB_W)
) chk_i (
  .clk(clk), .rst(rst), .ce_s(ce_s), .sle_s(sle_s), .rb_busy(rb_busy),
  .rb_cap(rb_cap), .sread_o(sread_o), .sread_en_o(sread_en_o), .regs_o(regs_o)
);

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb_top;
  localparam int NREG = 16;
  localparam int WW   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0, sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic [15:0] rbv = '0;
  logic sread, sread_en;
  logic [NREG*WW-1:0] regs;

  int n_chk = 0;
  int n_fail = 0;
  logic [WW-1:0] model [NREG];

  always #5 clk = ~clk;

  cfg_serial_port dut_i (
    .clk(clk), .rst(rst), .ce_i(ce), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
    .rb_value_i(rbv), .sread_o(sread), .sread_en_o(sread_en), .regs_o(regs)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    sdata = b;
    wait_n(4);
    sclk = 1'b1;
    wait_n(4);
    sclk = 1'b0;
    wait_n(2);
  endtask

  task automatic send_bits(input logic [63:0] w, input int n);
    for (int k = n - 1; k >= 0; k--) pulse_bit(w[k]);
  endtask

  task automatic load;
    sle = 1'b1;
    wait_n(6);
    sle = 1'b0;
    wait_n(6);
  endtask

  task automatic check_all(input string req);
    for (int r = 0; r < NREG; r++)
      chk(regs[r*WW +: WW] == model[r], req, 64'(regs[r*WW +: WW]), 64'(model[r]));
  endtask

  function automatic logic [WW-1:0] pattern(input int i);
    logic [WW-1:0] v;
    v = 32'h9E37_79B9 * (i + 3) ^ (32'h0101_0101 << (i % 8));
    v[3:0] = i[3:0];
    return v;
  endfunction

  task automatic readback(input logic [15:0] v);
    logic [WW-1:0] tw;
    tw = 32'h00AB_0107;
    rbv = v;
    send_bits(64'(tw), 32);
    sle = 1'b1;
    wait_n(6);
    model[7] = tw;
    rbv = ~v;  // R6: later change must not matter
    chk(!sread_en, "R7 released before first edge", 64'(sread_en), 0);
    for (int e = 1; e <= 20; e++) begin
      sdata = 1'b0;
      wait_n(2);
      sclk = 1'b1;
      wait_n(6);
      if (e == 1) begin
        chk(sread_en && !sread, "R7 dummy bit", {sread_en, sread}, 2'b10);
      end else if (e <= 17) begin
        chk(sread_en && sread == v[17-e], "R6 R7 data bit",
            {sread_en, sread}, {1'b1, v[17-e]});
      end else begin
        chk(!sread_en, "R8 release", 64'(sread_en), 0);
      end
      sclk = 1'b0;
      wait_n(4);
    end
    sle = 1'b0;
    wait_n(6);
    chk(regs[7*WW +: WW] == tw, "R3 request word stored", 64'(regs[7*WW +: WW]), 64'(tw));
  endtask

  initial begin
    #(10 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) model[r] = '0;
    wait_n(5);
    check_all("R1");
    chk(!sread_en, "R1 enable", 64'(sread_en), 0);
    rst = 1'b0;
    ce = 1'b1;
    wait_n(4);

    // R2 R3: sweep every index, check all registers each time
    for (int i = 0; i < NREG; i++) begin
      send_bits(64'(pattern(i)), 32);
      load();
      model[i] = pattern(i);
      check_all("R2 R3 sweep");
    end

    // R4: short word keeps older bits above it
    send_bits(64'h0000_0000_1234_5672, 32);
    load();
    model[2] = 32'h1234_5672;
    send_bits(64'h0000_0000_0000_BEE5, 16);
    load();
    model[5] = 32'h5672_BEE5;
    check_all("R4 short word");

    // R4: long word keeps last 32 bits
    send_bits(64'h0000_00FF_C0DE_F00C, 40);
    load();
    model[12] = 32'hC0DE_F00C;
    check_all("R4 long word");

    // R5: index 7 without request bit, and another index with bit 8 set
    send_bits(64'h0000_0000_0055_0007, 32);
    sle = 1'b1;
    wait_n(6);
    model[7] = 32'h0055_0007;
    for (int e = 0; e < 3; e++) begin
      pulse_bit(1'b0);
      chk(!sread_en, "R5 no request bit", 64'(sread_en), 0);
    end
    sle = 1'b0;
    wait_n(6);
    send_bits(64'h0000_0000_0000_0103, 32);
    sle = 1'b1;
    wait_n(6);
    model[3] = 32'h0000_0103;
    pulse_bit(1'b0);
    chk(!sread_en, "R5 wrong index", 64'(sread_en), 0);
    sle = 1'b0;
    wait_n(6);
    check_all("R5 stored");

    // R6 R7 R8: readback patterns
    readback(16'h0000);
    readback(16'hFFFF);
    readback(16'hA5C3);
    readback(16'h8001);
    readback(16'h5A5A);

    // R9: early strobe release
    rbv = 16'hFFFF;
    send_bits(64'h0000_0000_0000_0107, 32);
    sle = 1'b1;
    wait_n(6);
    model[7] = 32'h0000_0107;
    pulse_bit(1'b0);
    pulse_bit(1'b0);
    chk(sread_en, "R9 active before release", 64'(sread_en), 1);
    sle = 1'b0;
    wait_n(6);
    chk(!sread_en, "R9 release on strobe fall", 64'(sread_en), 0);

    // R11: chip enable drop mid-readback
    send_bits(64'h0000_0000_0000_0107, 32);
    sle = 1'b1;
    wait_n(6);
    pulse_bit(1'b0);
    pulse_bit(1'b0);
    chk(sread_en, "R11 active before ce drop", 64'(sread_en), 1);
    ce = 1'b0;
    wait_n(6);
    chk(!sread_en, "R11 release on ce low", 64'(sread_en), 0);
    sle = 1'b0;
    wait_n(6);
    ce = 1'b1;
    wait_n(6);

    // R10: activity with ce low is ignored (shift, load, readback)
    send_bits(64'h0000_0000_CAFE_0009, 32);
    ce = 1'b0;
    wait_n(4);
    send_bits(64'h0000_0000_DEAD_0107, 32);
    load();
    check_all("R10 no write with ce low");
    ce = 1'b1;
    wait_n(6);
    sle = 1'b1;
    wait_n(6);
    model[9] = 32'hCAFE_0009;
    pulse_bit(1'b0);
    chk(!sread_en, "R10 no readback started", 64'(sread_en), 0);
    sle = 1'b0;
    wait_n(6);
    check_all("R10 shift register held");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule